// File: doc/BRIEF.md
# Queued Interrupt Entry Controller

This block sequences interrupt entry and exit for a microcoded processor. Eight external request lines are edge-detected and priority-encoded into a 3-bit interrupt number. The numbers wait, in arrival order, in a three-entry queue. The number at the head of the queue and a pending bit are exported as processor flags.

Once an entry is pending, the controller waits for the processor to report an instruction boundary. It then marks the interrupt as active, selects the alternate register bank and holds the processor. Next it writes the context words to an external stack, one handshake per word. Last, it fetches the vector for the head number through a request/acknowledge port and loads it into the program counter.

On a return-from-interrupt strobe there are two outcomes. If the queue is empty, the controller pops the context back in reverse order and returns to the primary bank. If the queue still holds a number, it chains straight into the next service routine and leaves the stack untouched.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A request line counts when it rises. Line 7 has the highest priority. When several lines rise in the same cycle, only the highest of them is queued, as its line index.
- R2: The queue holds up to 3 numbers and delivers them in arrival order. One cycle after a rising edge, `flag_pending` is 1 and `flag_irq_num` shows the number at the head of the queue. While the queue is empty, `flag_irq_num` is 0.
- R3: Entry starts only at a clock edge where `instr_done` is 1 and the queue is non-empty. Until then nothing is pushed. `cpu_hold` rises only after an `instr_done` or `rti` strobe.
- R4: `flag_active` and `bank_alt` become 1 at the start of entry, before the first context push.
- R5: Context words are pushed in the order PC (word 0), then the index registers, then the offset registers, one word per accepted `push_valid`/`push_ready`. After that, `vec_req` is raised with `vec_num` equal to the head number. On `vec_ack`, `pc_load` carries `vec_data` and the head entry is removed.
- R6: On `rti` with an empty queue, the words are popped in reverse order. Each `pop_ack` drives `ctx_wr` with `ctx_sel` counting down from the last word to 0 (0 = PC) and `ctx_wdata` equal to `pop_data`.
- R7: On `rti` with a non-empty queue, the next vector is fetched and loaded at once, with no pop and no push.
- R8: A line that is held high queues exactly one entry.
- R9: A rising edge that arrives while the queue is full, and no entry is removed in that cycle, is dropped. It sets `flag_overflow`, which stays 1 until reset.
- R10: After the last restored word, `flag_active` and `bank_alt` return to 0.
- R11: A rising edge in the same cycle as a vector load on a full queue is accepted without overflow.
- R12: After reset, all flags, strobes and requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | External request lines |
| instr_done | input | 1 | Instruction boundary strobe |
| rti | input | 1 | Return-from-interrupt strobe |
| pc_in | input | 16 | Current program counter |
| idx_in | input | 32 | Index registers, word 0 in low bits |
| ofs_in | input | 32 | Offset registers, word 0 in low bits |
| push_valid | output | 1 | Stack push request |
| push_data | output | 16 | Word to push |
| push_ready | input | 1 | Stack accepts push |
| pop_req | output | 1 | Stack pop request |
| pop_ack | input | 1 | Pop data valid |
| pop_data | input | 16 | Popped word |
| ctx_wr | output | 1 | Restore write strobe |
| ctx_sel | output | 3 | Restored word index |
| ctx_wdata | output | 16 | Restored word |
| vec_req | output | 1 | Vector fetch request |
| vec_num | output | 3 | Number whose vector is fetched |
| vec_ack | input | 1 | Vector data valid |
| vec_data | input | 16 | Vector address |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | 16 | Program counter load value |
| flag_irq_num | output | 3 | Head interrupt number |
| flag_pending | output | 1 | Queue non-empty |
| flag_active | output | 1 | Interrupt active |
| bank_alt | output | 1 | Alternate register bank selected |
| flag_overflow | output | 1 | Sticky drop flag |
| cpu_hold | output | 1 | Processor stalled by sequence |

## Verification
A new request can reach the queue in the same cycle that a vector load removes the head. On a full queue, that is the one cycle where a push is legal only because of the pop. The bench provokes it by filling the queue and then holding off `vec_ack`. While the vector request waits, it raises a fresh line and releases the acknowledge at the same edge. The collision is judged correct if `flag_overflow` stays 0, the head moves to the second entry, and the later chained loads deliver all four vectors in arrival order.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_VEC,
        ST_ISR,
        ST_RESTORE
    } seq_state_e;

endpackage

// File: rtl/irq_edge_encoder.sv
module irq_edge_encoder #(
    parameter int LINES = 8,
    localparam int NUM_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req,
    output logic             push_en,
    output logic [NUM_W-1:0] push_num
);

    logic [LINES-1:0] req_d, req_q;
    logic [LINES-1:0] rise;

    always_comb begin
        req_d    = req;
        rise     = req & ~req_q;
        push_en  = |rise;
        push_num = '0;
        // later (higher) lines overwrite lower ones: highest wins
        for (int i = 0; i < LINES; i++) begin
            if (rise[i]) push_num = NUM_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

endmodule

// File: rtl/irq_num_fifo.sv
module irq_num_fifo #(
    parameter int DEPTH = 3,
    parameter int NUM_W = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [NUM_W-1:0] push_num,
    input  logic             pop,
    output logic [NUM_W-1:0] head_num,
    output logic             not_empty,
    output logic             overflow
);

    typedef struct packed {
        logic [DEPTH-1:0][NUM_W-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            count;
        logic                        ovf;
    } fifo_t;

    fifo_t fq_d, fq_q;
    logic  pop_ok, accept, full;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        fq_d   = fq_q;
        full   = (fq_q.count == CNT_W'(DEPTH));
        pop_ok = pop && (fq_q.count != '0);
        accept = push && (!full || pop_ok);
        if (accept) begin
            fq_d.mem[fq_q.wr] = push_num;
            fq_d.wr           = ptr_next(fq_q.wr);
        end
        if (pop_ok) fq_d.rd = ptr_next(fq_q.rd);
        if (accept && !pop_ok)      fq_d.count = fq_q.count + CNT_W'(1);
        else if (!accept && pop_ok) fq_d.count = fq_q.count - CNT_W'(1);
        if (push && !accept) fq_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fq_q <= '0;
        else        fq_q <= fq_d;
    end

    assign not_empty = (fq_q.count != '0);
    assign head_num  = not_empty ? fq_q.mem[fq_q.rd] : '0;
    assign overflow  = fq_q.ovf;

endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
    import irq_entry_pkg::*;
#(
    parameter int W     = 16,
    parameter int CTX_N = 5,
    parameter int NUM_W = 3,
    localparam int SEL_W = $clog2(CTX_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pending,
    input  logic [NUM_W-1:0]   head_num,
    input  logic               instr_done,
    input  logic               rti,
    input  logic [CTX_N*W-1:0] ctx_words,
    output logic               push_valid,
    output logic [W-1:0]       push_data,
    input  logic               push_ready,
    output logic               pop_req,
    input  logic               pop_ack,
    input  logic [W-1:0]       pop_data,
    output logic               ctx_wr,
    output logic [SEL_W-1:0]   ctx_sel,
    output logic [W-1:0]       ctx_wdata,
    output logic               vec_req,
    output logic [NUM_W-1:0]   vec_num,
    input  logic               vec_ack,
    input  logic [W-1:0]       vec_data,
    output logic               pc_load,
    output logic [W-1:0]       pc_value,
    output logic               fifo_pop,
    output logic               active,
    output logic               bank_alt,
    output logic               cpu_hold
);

    localparam logic [SEL_W-1:0] LAST = SEL_W'(CTX_N - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [SEL_W-1:0] idx;
        logic             active;
        logic             bank;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d       = sq_q;
        push_valid = 1'b0;
        push_data  = '0;
        pop_req    = 1'b0;
        ctx_wr     = 1'b0;
        ctx_sel    = '0;
        ctx_wdata  = '0;
        vec_req    = 1'b0;
        pc_load    = 1'b0;
        pc_value   = '0;
        fifo_pop   = 1'b0;
        unique case (sq_q.state)
            ST_IDLE: begin
                if (instr_done && pending) begin
                    sq_d.state  = ST_SAVE;
                    sq_d.idx    = '0;
                    sq_d.active = 1'b1;
                    sq_d.bank   = 1'b1;
                end
            end
            ST_SAVE: begin
                push_valid = 1'b1;
                push_data  = ctx_words[int'(sq_q.idx)*W +: W];
                if (push_ready) begin
                    if (sq_q.idx == LAST) sq_d.state = ST_VEC;
                    else                  sq_d.idx   = sq_q.idx + SEL_W'(1);
                end
            end
            ST_VEC: begin
                vec_req = 1'b1;
                if (vec_ack) begin
                    pc_load    = 1'b1;
                    pc_value   = vec_data;
                    fifo_pop   = 1'b1;
                    sq_d.state = ST_ISR;
                end
            end
            ST_ISR: begin
                if (rti) begin
                    if (pending) begin
                        sq_d.state = ST_VEC;
                    end else begin
                        sq_d.state = ST_RESTORE;
                        sq_d.idx   = LAST;
                    end
                end
            end
            ST_RESTORE: begin
                pop_req = 1'b1;
                if (pop_ack) begin
                    ctx_wr    = 1'b1;
                    ctx_sel   = sq_q.idx;
                    ctx_wdata = pop_data;
                    if (sq_q.idx == '0) begin
                        sq_d.state  = ST_IDLE;
                        sq_d.active = 1'b0;
                        sq_d.bank   = 1'b0;
                    end else begin
                        sq_d.idx = sq_q.idx - SEL_W'(1);
                    end
                end
            end
            default: sq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '{state: ST_IDLE, idx: '0, active: 1'b0, bank: 1'b0};
        else        sq_q <= sq_d;
    end

    assign vec_num  = head_num;
    assign active   = sq_q.active;
    assign bank_alt = sq_q.bank;
    assign cpu_hold = (sq_q.state == ST_SAVE) || (sq_q.state == ST_VEC)
                   || (sq_q.state == ST_RESTORE);

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
    parameter int LINES      = 8,
    parameter int FIFO_DEPTH = 3,
    parameter int W          = 16,
    parameter int NUM_IDX    = 2,
    parameter int NUM_OFS    = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [LINES-1:0]                        irq_req,
    input  logic                                    instr_done,
    input  logic                                    rti,
    input  logic [W-1:0]                            pc_in,
    input  logic [NUM_IDX*W-1:0]                    idx_in,
    input  logic [NUM_OFS*W-1:0]                    ofs_in,
    output logic                                    push_valid,
    output logic [W-1:0]                            push_data,
    input  logic                                    push_ready,
    output logic                                    pop_req,
    input  logic                                    pop_ack,
    input  logic [W-1:0]                            pop_data,
    output logic                                    ctx_wr,
    output logic [$clog2(NUM_IDX+NUM_OFS+1)-1:0]    ctx_sel,
    output logic [W-1:0]                            ctx_wdata,
    output logic                                    vec_req,
    output logic [$clog2(LINES)-1:0]                vec_num,
    input  logic                                    vec_ack,
    input  logic [W-1:0]                            vec_data,
    output logic                                    pc_load,
    output logic [W-1:0]                            pc_value,
    output logic [$clog2(LINES)-1:0]                flag_irq_num,
    output logic                                    flag_pending,
    output logic                                    flag_active,
    output logic                                    bank_alt,
    output logic                                    flag_overflow,
    output logic                                    cpu_hold
);

    localparam int NUM_W = $clog2(LINES);
    localparam int CTX_N = 1 + NUM_IDX + NUM_OFS;

    logic               enc_push;
    logic [NUM_W-1:0]   enc_num;
    logic               fifo_pop;
    logic [NUM_W-1:0]   head_num;
    logic               pending;
    logic [CTX_N*W-1:0] ctx_words;

    // word 0 = PC, then index registers, then offset registers
    assign ctx_words = {ofs_in, idx_in, pc_in};

    irq_edge_encoder #(.LINES(LINES)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (irq_req),
        .push_en  (enc_push),
        .push_num (enc_num)
    );

    irq_num_fifo #(.DEPTH(FIFO_DEPTH), .NUM_W(NUM_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (enc_push),
        .push_num  (enc_num),
        .pop       (fifo_pop),
        .head_num  (head_num),
        .not_empty (pending),
        .overflow  (flag_overflow)
    );

    irq_ctx_seq #(.W(W), .CTX_N(CTX_N), .NUM_W(NUM_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .head_num   (head_num),
        .instr_done (instr_done),
        .rti        (rti),
        .ctx_words  (ctx_words),
        .push_valid (push_valid),
        .push_data  (push_data),
        .push_ready (push_ready),
        .pop_req    (pop_req),
        .pop_ack    (pop_ack),
        .pop_data   (pop_data),
        .ctx_wr     (ctx_wr),
        .ctx_sel    (ctx_sel),
        .ctx_wdata  (ctx_wdata),
        .vec_req    (vec_req),
        .vec_num    (vec_num),
        .vec_ack    (vec_ack),
        .vec_data   (vec_data),
        .pc_load    (pc_load),
        .pc_value   (pc_value),
        .fifo_pop   (fifo_pop),
        .active     (flag_active),
        .bank_alt   (bank_alt),
        .cpu_hold   (cpu_hold)
    );

    assign flag_irq_num = head_num;
    assign flag_pending = pending;

endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic instr_done,
    input logic rti,
    input logic push_valid,
    input logic pop_req,
    input logic vec_req,
    input logic flag_active,
    input logic bank_alt,
    input logic flag_overflow,
    input logic cpu_hold
);

    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow |=> flag_overflow);

    // R4
    push_in_alt_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> (flag_active && bank_alt));

    // R3
    hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_hold) |-> ($past(instr_done) || $past(rti)));

    // R5
    one_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_valid, pop_req, vec_req}));

    // R10
    bank_follows_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_active |-> !bank_alt);

    // R6
    restore_while_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |-> flag_active);

    // R7
    vector_in_alt_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_req) |-> bank_alt);

endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_done    (instr_done),
    .rti           (rti),
    .push_valid    (push_valid),
    .pop_req       (pop_req),
    .vec_req       (vec_req),
    .flag_active   (flag_active),
    .bank_alt      (bank_alt),
    .flag_overflow (flag_overflow),
    .cpu_hold      (cpu_hold)
);

// File: tb/irq_entry_ctrl_tb.sv
module irq_entry_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_req = '0;
    logic        instr_done = 1'b0, rti = 1'b0;
    logic [15:0] pc_in = '0;
    logic [31:0] idx_in = '0, ofs_in = '0;
    logic        push_valid, pop_req, ctx_wr, vec_req, pc_load;
    logic [15:0] push_data, ctx_wdata, pc_value, pop_data, vec_data;
    logic        push_ready = 1'b1, pop_ack = 1'b1, vec_ack = 1'b1;
    logic [2:0]  ctx_sel, vec_num, flag_irq_num;
    logic        flag_pending, flag_active, bank_alt, flag_overflow, cpu_hold;

    int checks = 0, errors = 0;
    logic [15:0] stack [16];
    int sp = 0, n_push = 0, n_wr = 0, n_pcl = 0;
    logic [15:0] wr_data [256];
    logic [2:0]  wr_sel [256];
    logic [15:0] pcl [256];

    always #4 clk = ~clk;

    irq_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_done(instr_done),
        .rti(rti), .pc_in(pc_in), .idx_in(idx_in), .ofs_in(ofs_in),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .pop_req(pop_req), .pop_ack(pop_ack), .pop_data(pop_data),
        .ctx_wr(ctx_wr), .ctx_sel(ctx_sel), .ctx_wdata(ctx_wdata),
        .vec_req(vec_req), .vec_num(vec_num), .vec_ack(vec_ack), .vec_data(vec_data),
        .pc_load(pc_load), .pc_value(pc_value), .flag_irq_num(flag_irq_num),
        .flag_pending(flag_pending), .flag_active(flag_active), .bank_alt(bank_alt),
        .flag_overflow(flag_overflow), .cpu_hold(cpu_hold)
    );

    // stack and vector table models
    assign pop_data = (sp > 0) ? stack[sp-1] : 16'h0;
    assign vec_data = 16'hA000 + {9'd0, vec_num, 4'd0};

    function automatic logic [15:0] vec_of(input int num);
        return 16'hA000 + 16'(num * 16);
    endfunction

    always @(posedge clk) begin
        if (push_valid && push_ready) begin stack[sp] = push_data; sp = sp + 1; n_push = n_push + 1; end
        if (pop_req && pop_ack) sp = sp - 1;
        if (ctx_wr) begin wr_sel[n_wr] = ctx_sel; wr_data[n_wr] = ctx_wdata; n_wr = n_wr + 1; end
        if (pc_load) begin pcl[n_pcl] = pc_value; n_pcl = n_pcl + 1; end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_req = '0; instr_done = 1'b0; rti = 1'b0; vec_ack = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_ctx(input int n);
        logic [15:0] b;
        b = 16'h1000 + 16'(n * 16);
        pc_in  = b;
        idx_in = {b + 16'd2, b + 16'd1};
        ofs_in = {b + 16'd4, b + 16'd3};
    endtask

    task automatic rise_line(input int line);
        @(negedge clk) irq_req = 8'(1 << line);
        @(negedge clk) irq_req = '0;
    endtask

    task automatic pulse_done();
        @(negedge clk) instr_done = 1'b1;
        @(negedge clk) instr_done = 1'b0;
    endtask

    task automatic pulse_rti();
        @(negedge clk) rti = 1'b1;
        @(negedge clk) rti = 1'b0;
    endtask

    task automatic wait_isr();
        while (cpu_hold || !flag_active) @(negedge clk);
    endtask

    task automatic wait_exit();
        while (flag_active || cpu_hold) @(negedge clk);
    endtask

    // full entry / exit for a single line
    task automatic serve_one(input int n);
        int p0, w0, l0;
        logic [15:0] b;
        do_reset();
        set_ctx(n);
        b = 16'h1000 + 16'(n * 16);
        p0 = n_push; w0 = n_wr; l0 = n_pcl;
        rise_line(n);
        chk("R2 pending", int'(flag_pending), 1);
        chk("R1 number", int'(flag_irq_num), n);
        repeat (4) @(negedge clk);
        chk("R3 no push before boundary", n_push - p0, 0);
        chk("R3 inactive before boundary", int'(flag_active), 0);
        pulse_done();
        wait_isr();
        chk("R5 words pushed", n_push - p0, 5);
        for (int k = 0; k < 5; k++) chk("R5 push order", int'(stack[sp-5+k]), int'(b) + k);
        chk("R5 vector load", int'(pcl[n_pcl-1]), int'(vec_of(n)));
        chk("R5 one load", n_pcl - l0, 1);
        chk("R4 active", int'(flag_active), 1);
        chk("R4 bank", int'(bank_alt), 1);
        chk("R5 head removed", int'(flag_pending), 0);
        pulse_rti();
        wait_exit();
        chk("R6 words restored", n_wr - w0, 5);
        for (int k = 0; k < 5; k++) begin
            chk("R6 restore sel", int'(wr_sel[w0+k]), 4 - k);
            chk("R6 restore data", int'(wr_data[w0+k]), int'(b) + 4 - k);
        end
        chk("R10 bank back", int'(bank_alt), 0);
        chk("R10 inactive", int'(flag_active), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int p0, w0, l0;
        do_reset();
        // R12 reset state
        chk("R12 pending", int'(flag_pending), 0);
        chk("R12 num", int'(flag_irq_num), 0);
        chk("R12 active", int'(flag_active), 0);
        chk("R12 bank", int'(bank_alt), 0);
        chk("R12 overflow", int'(flag_overflow), 0);
        chk("R12 strobes", int'({push_valid, pop_req, vec_req, pc_load, ctx_wr, cpu_hold}), 0);

        for (int n = 0; n < 8; n++) serve_one(n);

        // R1 simultaneous rises: only the highest is queued
        do_reset(); set_ctx(9);
        @(negedge clk) irq_req = 8'b0100_1000;
        @(negedge clk) irq_req = '0;
        chk("R1 highest of two", int'(flag_irq_num), 6);
        pulse_done(); wait_isr();
        chk("R1 single entry", int'(flag_pending), 0);
        pulse_rti(); wait_exit();
        @(negedge clk) irq_req = 8'hFF;
        @(negedge clk) irq_req = '0;
        chk("R1 all lines", int'(flag_irq_num), 7);
        pulse_done(); wait_isr();
        chk("R1 all lines single", int'(flag_pending), 0);
        pulse_rti(); wait_exit();

        // R8 held line queues once
        do_reset();
        @(negedge clk) irq_req = 8'h10;
        repeat (10) @(negedge clk);
        chk("R8 queued", int'(flag_irq_num), 4);
        pulse_done(); wait_isr();
        chk("R8 once", int'(flag_pending), 0);
        pulse_rti(); wait_exit();
        repeat (3) @(negedge clk);
        chk("R8 no requeue", int'(flag_pending), 0);
        irq_req = '0;

        // R7 chaining in arrival order, no stack traffic between
        do_reset();
        l0 = n_pcl;
        rise_line(6); rise_line(2);
        chk("R2 head is first arrival", int'(flag_irq_num), 6);
        pulse_done(); wait_isr();
        chk("R7 first vector", int'(pcl[n_pcl-1]), int'(vec_of(6)));
        p0 = n_push; w0 = n_wr;
        pulse_rti(); wait_isr();
        chk("R7 chained vector", int'(pcl[n_pcl-1]), int'(vec_of(2)));
        chk("R7 no pushes", n_push - p0, 0);
        chk("R7 no restores", n_wr - w0, 0);
        chk("R7 still alt bank", int'(bank_alt), 1);
        pulse_rti(); wait_exit();
        chk("R6 restore after chain", n_wr - w0, 5);
        chk("R5 two loads", n_pcl - l0, 2);

        // R9 overflow drop and stickiness
        do_reset();
        l0 = n_pcl;
        rise_line(1); rise_line(2); rise_line(3);
        chk("R9 no overflow at three", int'(flag_overflow), 0);
        rise_line(5);
        chk("R9 overflow set", int'(flag_overflow), 1);
        chk("R9 head unchanged", int'(flag_irq_num), 1);
        pulse_done(); wait_isr();
        pulse_rti(); wait_isr();
        pulse_rti(); wait_isr();
        chk("R9 empty after three", int'(flag_pending), 0);
        pulse_rti(); wait_exit();
        chk("R9 three loads", n_pcl - l0, 3);
        for (int k = 0; k < 3; k++) chk("R9 load order", int'(pcl[l0+k]), int'(vec_of(k + 1)));
        chk("R9 sticky", int'(flag_overflow), 1);

        // R11 push and pop in the same cycle on a full queue
        do_reset();
        l0 = n_pcl;
        rise_line(1); rise_line(2); rise_line(3);
        vec_ack = 1'b0;
        pulse_done();
        while (!vec_req) @(negedge clk);
        irq_req = 8'h10; vec_ack = 1'b1;
        @(negedge clk) irq_req = '0;
        chk("R11 no overflow", int'(flag_overflow), 0);
        chk("R11 head advanced", int'(flag_irq_num), 2);
        wait_isr();
        pulse_rti(); wait_isr();
        pulse_rti(); wait_isr();
        pulse_rti(); wait_isr();
        pulse_rti(); wait_exit();
        chk("R11 four loads", n_pcl - l0, 4);
        for (int k = 0; k < 4; k++) chk("R11 load order", int'(pcl[l0+k]), int'(vec_of(k + 1)));
        chk("R11 overflow still clear", int'(flag_overflow), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule